// File: doc/BRIEF.md
# BCD Time-of-Day and Calendar Counter

This core holds the time of day and the calendar date as packed BCD words. It advances them once for every pulse on a one-second tick input. Seconds, minutes and hours roll into the day. The day of month, month, year and century follow month lengths and leap years. A day-of-week field cycles beside the date. Hours count in either a 24-hour or a 12-hour format, and the 12-hour format uses a PM flag.

A host reaches the core through a small word-indexed register bus, with a write strobe and a combinational read. To set new values, the host raises a hold request for the time word, the calendar word, or both. It then waits for the update-acknowledge status, which is granted only on a second boundary. Next it writes the new words and drops the requests, and counting resumes from the written values. A second-event status flag is raised on every tick. Both status flags are sticky and are cleared by writing ones to a clear register.

Register indices on `bus_addr` are: 0 control, 1 format, 2 time, 3 calendar, 4 status (read-only), 5 status clear (write-only, reads as zero).

Top module: `bcd_rtc_core`

## Requirements
- R1: After reset the time word reads 0x00000000. The calendar word reads 0x01210020, which is 2000-01-01 with day of week 1. Control, format and status read as zero.
- R2: Field positions: the time word has seconds in bits 6:0, minutes in 14:8, hours in 21:16 and PM in bit 22. The calendar word has century in 6:0, year in 15:8, month (1-12) in 20:16, day of week (1-7) in 23:21 and day of month in 29:24. With format bit 0 clear, each tick adds one BCD second, seconds and minutes wrap 59 to 00 with a carry, and hours wrap 23 to 00 and advance the calendar by one day.
- R3: With format bit 0 set, hours run 12, 01 to 11. Going from 11 to 12 toggles PM. Going from 12 to 01 does not toggle PM. Passing 11:59:59 PM gives 12:00:00 AM and advances the calendar by one day.
- R4: A day advance at the month's last day sets the day to 01 and advances the month. April, June, September and November have 30 days. February has 29 days in a leap year and 28 otherwise. A year is a leap year if the year field is nonzero and divisible by 4, or if the year field is 00 and the century is divisible by 4. Month 12 wraps to 01 and advances the year.
- R5: Year 99 wraps to 00 and advances the century by one.
- R6: Every day advance increments the day of week, and 7 wraps to 1.
- R7: While control bit 0 is set the time word does not count. While control bit 1 is set the calendar word does not count, and any day carry from the time word is discarded.
- R8: Status bit 0 (update acknowledge) sets only on a tick during which a hold request is already registered. It never sets on the cycle the request is written.
- R9: A write to the time word takes effect only while control bit 0 and status bit 0 are both set. A write to the calendar word takes effect only while control bit 1 and status bit 0 are both set. Any other such write is ignored.
- R10: Once both control bits are cleared, the words read back exactly as written, and the next tick counts on from them.
- R11: Status bit 2 (second event) sets on every tick, including while counting is held. Writing a one to bit 0 or bit 2 of the clear register clears the matching status bit.
- R12: With no tick and no write, two consecutive reads of the time and calendar words return the same values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_1hz | input | 1 | One-cycle pulse per second |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register index for read and write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |

## Verification
Every write and every tick changes its register on the clock edge that samples it. The read path is combinational, so a result is visible on the falling edge straight after that rising edge.

The bench drives the strobe and the tick on a falling edge and releases them on the next falling edge, so each stimulus covers exactly one rising edge. It reads the result a fraction of a period after a later falling edge. The acknowledge is a special case: it is checked both before the first tick after the request and straight after that tick, which shows it is due on that tick and not sooner.

// File: rtl/bcd_rtc_pkg.sv
package bcd_rtc_pkg;

    localparam int unsigned WORD_W    = 32;
    localparam int unsigned REG_IDX_W = 3;

    localparam int unsigned CTRL_TOD_BIT = 0;
    localparam int unsigned CTRL_CAL_BIT = 1;
    localparam int unsigned STAT_ACK_BIT = 0;
    localparam int unsigned STAT_SEV_BIT = 2;

    typedef enum logic [REG_IDX_W-1:0] {
        REG_CTRL = 3'd0,
        REG_FMT  = 3'd1,
        REG_TOD  = 3'd2,
        REG_CAL  = 3'd3,
        REG_STAT = 3'd4,
        REG_SCLR = 3'd5
    } reg_idx_e;

    typedef struct packed {
        logic       pm;
        logic [5:0] hour;
        logic [6:0] min;
        logic [6:0] sec;
    } tod_t;

    typedef struct packed {
        logic [5:0] mday;
        logic [2:0] wday;
        logic [4:0] mon;
        logic [7:0] year;
        logic [6:0] cent;
    } cal_t;

    localparam tod_t TOD_RST = '{pm: 1'b0, hour: 6'h00, min: 7'h00, sec: 7'h00};
    localparam cal_t CAL_RST = '{mday: 6'h01, wday: 3'd1, mon: 5'h01,
                                 year: 8'h00, cent: 7'h20};

    function automatic logic [7:0] bcd_inc(input logic [7:0] v);
        if (v[3:0] >= 4'd9) return {v[7:4] + 4'd1, 4'd0};
        else                return {v[7:4], v[3:0] + 4'd1};
    endfunction

    function automatic logic [7:0] bcd_to_bin(input logic [7:0] v);
        return ({4'd0, v[7:4]} * 8'd10) + {4'd0, v[3:0]};
    endfunction

    function automatic logic is_leap(input logic [7:0] year, input logic [6:0] cent);
        logic [7:0] yb;
        logic [7:0] cb;
        yb = bcd_to_bin(year);
        cb = bcd_to_bin({1'b0, cent});
        if (yb != 8'd0) return (yb[1:0] == 2'b00);
        else            return (cb[1:0] == 2'b00);
    endfunction

    function automatic logic [5:0] last_mday(input logic [4:0] mon, input logic leap);
        case (mon)
            5'h02:                      return leap ? 6'h29 : 6'h28;
            5'h04, 5'h06, 5'h09, 5'h11: return 6'h30;
            default:                    return 6'h31;
        endcase
    endfunction

    function automatic logic [WORD_W-1:0] pack_tod(input tod_t t);
        return {9'd0, t.pm, t.hour, 1'b0, t.min, 1'b0, t.sec};
    endfunction

    function automatic tod_t unpack_tod(input logic [WORD_W-1:0] w);
        tod_t t;
        t.pm   = w[22];
        t.hour = w[21:16];
        t.min  = w[14:8];
        t.sec  = w[6:0];
        return t;
    endfunction

    function automatic logic [WORD_W-1:0] pack_cal(input cal_t c);
        return {2'd0, c.mday, c.wday, c.mon, c.year, 1'b0, c.cent};
    endfunction

    function automatic cal_t unpack_cal(input logic [WORD_W-1:0] w);
        cal_t c;
        c.mday = w[29:24];
        c.wday = w[23:21];
        c.mon  = w[20:16];
        c.year = w[15:8];
        c.cent = w[6:0];
        return c;
    endfunction

endpackage

// File: rtl/rtc_tod_cnt.sv
module rtc_tod_cnt
    import bcd_rtc_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic adv,
    input  logic fmt12,
    input  logic ld,
    input  tod_t ld_val,
    output tod_t cur,
    output logic day_wrap
);

    tod_t       nxt;
    logic [7:0] sec_inc;
    logic [7:0] min_inc;
    logic [7:0] hour_inc;

    assign sec_inc  = bcd_inc({1'b0, cur.sec});
    assign min_inc  = bcd_inc({1'b0, cur.min});
    assign hour_inc = bcd_inc({2'b0, cur.hour});

    always_comb begin
        nxt      = cur;
        day_wrap = 1'b0;
        if (adv) begin
            if (cur.sec == 7'h59) begin
                nxt.sec = 7'h00;
                if (cur.min == 7'h59) begin
                    nxt.min = 7'h00;
                    if (fmt12) begin
                        if (cur.hour == 6'h11) begin
                            nxt.hour = 6'h12;
                            nxt.pm   = ~cur.pm;
                            day_wrap = cur.pm;
                        end else if (cur.hour == 6'h12) begin
                            nxt.hour = 6'h01;
                        end else begin
                            nxt.hour = hour_inc[5:0];
                        end
                    end else begin
                        if (cur.hour == 6'h23) begin
                            nxt.hour = 6'h00;
                            day_wrap = 1'b1;
                        end else begin
                            nxt.hour = hour_inc[5:0];
                        end
                    end
                end else begin
                    nxt.min = min_inc[6:0];
                end
            end else begin
                nxt.sec = sec_inc[6:0];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst)     cur <= TOD_RST;
        else if (ld) cur <= ld_val;
        else         cur <= nxt;
    end

endmodule

// File: rtl/rtc_cal_cnt.sv
module rtc_cal_cnt
    import bcd_rtc_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic adv,
    input  logic ld,
    input  cal_t ld_val,
    output cal_t cur
);

    cal_t       nxt;
    logic [5:0] end_day;
    logic [7:0] mday_inc;
    logic [7:0] mon_inc;
    logic [7:0] year_inc;
    logic [7:0] cent_inc;

    assign end_day  = last_mday(cur.mon, is_leap(cur.year, cur.cent));
    assign mday_inc = bcd_inc({2'b0, cur.mday});
    assign mon_inc  = bcd_inc({3'b0, cur.mon});
    assign year_inc = bcd_inc(cur.year);
    assign cent_inc = bcd_inc({1'b0, cur.cent});

    always_comb begin
        nxt = cur;
        if (adv) begin
            nxt.wday = (cur.wday >= 3'd7) ? 3'd1 : cur.wday + 3'd1;
            if (cur.mday == end_day) begin
                nxt.mday = 6'h01;
                if (cur.mon == 5'h12) begin
                    nxt.mon = 5'h01;
                    if (cur.year == 8'h99) begin
                        nxt.year = 8'h00;
                        nxt.cent = cent_inc[6:0];
                    end else begin
                        nxt.year = year_inc;
                    end
                end else begin
                    nxt.mon = mon_inc[4:0];
                end
            end else begin
                nxt.mday = mday_inc[5:0];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst)     cur <= CAL_RST;
        else if (ld) cur <= ld_val;
        else         cur <= nxt;
    end

endmodule

// File: rtl/rtc_upd_ctrl.sv
module rtc_upd_ctrl
    import bcd_rtc_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic ctrl_we,
    input  logic ctrl_tod,
    input  logic ctrl_cal,
    input  logic sclr_we,
    input  logic sclr_ack,
    input  logic sclr_sev,
    output logic hold_tod,
    output logic hold_cal,
    output logic ack,
    output logic sev
);

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_tod <= 1'b0;
            hold_cal <= 1'b0;
        end else if (ctrl_we) begin
            hold_tod <= ctrl_tod;
            hold_cal <= ctrl_cal;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ack <= 1'b0;
            sev <= 1'b0;
        end else begin
            if (tick && (hold_tod || hold_cal)) ack <= 1'b1;
            else if (sclr_we && sclr_ack)       ack <= 1'b0;
            if (tick)                           sev <= 1'b1;
            else if (sclr_we && sclr_sev)       sev <= 1'b0;
        end
    end

endmodule

// File: rtl/bcd_rtc_core.sv
module bcd_rtc_core
    import bcd_rtc_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 tick_1hz,
    input  logic                 bus_we,
    input  logic [REG_IDX_W-1:0] bus_addr,
    input  logic [WORD_W-1:0]    bus_wdata,
    output logic [WORD_W-1:0]    bus_rdata
);

    tod_t tod_cur;
    cal_t cal_cur;
    logic day_wrap;
    logic fmt12;
    logic hold_tod;
    logic hold_cal;
    logic ack;
    logic sev;
    logic we_ctrl;
    logic we_fmt;
    logic we_tod;
    logic we_cal;
    logic we_sclr;
    logic ld_tod;
    logic ld_cal;
    logic [WORD_W-1:0] tod_word;
    logic [WORD_W-1:0] cal_word;
    logic [WORD_W-1:0] stat_word;

    assign we_ctrl = bus_we && (bus_addr == REG_CTRL);
    assign we_fmt  = bus_we && (bus_addr == REG_FMT);
    assign we_tod  = bus_we && (bus_addr == REG_TOD);
    assign we_cal  = bus_we && (bus_addr == REG_CAL);
    assign we_sclr = bus_we && (bus_addr == REG_SCLR);

    assign ld_tod = we_tod && hold_tod && ack;
    assign ld_cal = we_cal && hold_cal && ack;

    always_ff @(posedge clk) begin
        if (rst)         fmt12 <= 1'b0;
        else if (we_fmt) fmt12 <= bus_wdata[0];
    end

    rtc_upd_ctrl upd_i (
        .clk      (clk),
        .rst      (rst),
        .tick     (tick_1hz),
        .ctrl_we  (we_ctrl),
        .ctrl_tod (bus_wdata[CTRL_TOD_BIT]),
        .ctrl_cal (bus_wdata[CTRL_CAL_BIT]),
        .sclr_we  (we_sclr),
        .sclr_ack (bus_wdata[STAT_ACK_BIT]),
        .sclr_sev (bus_wdata[STAT_SEV_BIT]),
        .hold_tod (hold_tod),
        .hold_cal (hold_cal),
        .ack      (ack),
        .sev      (sev)
    );

    rtc_tod_cnt tod_i (
        .clk      (clk),
        .rst      (rst),
        .adv      (tick_1hz && !hold_tod),
        .fmt12    (fmt12),
        .ld       (ld_tod),
        .ld_val   (unpack_tod(bus_wdata)),
        .cur      (tod_cur),
        .day_wrap (day_wrap)
    );

    rtc_cal_cnt cal_i (
        .clk    (clk),
        .rst    (rst),
        .adv    (day_wrap && !hold_cal),
        .ld     (ld_cal),
        .ld_val (unpack_cal(bus_wdata)),
        .cur    (cal_cur)
    );

    assign tod_word  = pack_tod(tod_cur);
    assign cal_word  = pack_cal(cal_cur);
    assign stat_word = {{(WORD_W-3){1'b0}}, sev, 1'b0, ack};

    always_comb begin
        case (bus_addr)
            REG_CTRL: bus_rdata = {{(WORD_W-2){1'b0}}, hold_cal, hold_tod};
            REG_FMT:  bus_rdata = {{(WORD_W-1){1'b0}}, fmt12};
            REG_TOD:  bus_rdata = tod_word;
            REG_CAL:  bus_rdata = cal_word;
            REG_STAT: bus_rdata = stat_word;
            default:  bus_rdata = '0;
        endcase
    end

endmodule

// File: rtl/bcd_rtc_core_chk.sv
module bcd_rtc_core_chk
    import bcd_rtc_pkg::*;
(
    input logic                 clk,
    input logic                 rst,
    input logic                 tick_1hz,
    input logic                 bus_we,
    input logic [REG_IDX_W-1:0] bus_addr,
    input logic                 hold_tod,
    input logic                 hold_cal,
    input logic                 ack,
    input logic                 sev,
    input logic [WORD_W-1:0]    tod_word,
    input logic [WORD_W-1:0]    cal_word
);

    // R8
    ack_only_on_tick_chk: assert property (@(posedge clk) disable iff (rst)
        (!ack && !tick_1hz) |=> !ack);

    // R11
    sev_on_tick_chk: assert property (@(posedge clk) disable iff (rst)
        tick_1hz |=> sev);

    // R7
    tod_frozen_chk: assert property (@(posedge clk) disable iff (rst)
        (hold_tod && !(bus_we && bus_addr == REG_TOD)) |=> $stable(tod_word));

    // R7
    cal_frozen_chk: assert property (@(posedge clk) disable iff (rst)
        (hold_cal && !(bus_we && bus_addr == REG_CAL)) |=> $stable(cal_word));

    // R12
    quiet_stable_chk: assert property (@(posedge clk) disable iff (rst)
        (!tick_1hz && !bus_we) |=> ($stable(tod_word) && $stable(cal_word)));

    // R9
    tod_wr_gate_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_we && bus_addr == REG_TOD && !(hold_tod && ack) && !tick_1hz)
        |=> $stable(tod_word));

endmodule

bind bcd_rtc_core bcd_rtc_core_chk chk_i (
    .clk      (clk),
    .rst      (rst),
    .tick_1hz (tick_1hz),
    .bus_we   (bus_we),
    .bus_addr (bus_addr),
    .hold_tod (hold_tod),
    .hold_cal (hold_cal),
    .ack      (ack),
    .sev      (sev),
    .tod_word (tod_word),
    .cal_word (cal_word)
);

// File: tb/bcd_rtc_core_tb_top.sv
module bcd_rtc_core_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tick_1hz = 1'b0;
    logic        bus_we = 1'b0;
    logic [2:0]  bus_addr = 3'd0;
    logic [31:0] bus_wdata = 32'd0;
    logic [31:0] bus_rdata;

    int  n_chk = 0;
    int  n_fail = 0;
    bit  done = 1'b0;

    always #2 clk = ~clk;

    bcd_rtc_core dut_i (
        .clk       (clk),
        .rst       (rst),
        .tick_1hz  (tick_1hz),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic tick();
        @(negedge clk);
        tick_1hz = 1'b1;
        @(negedge clk);
        tick_1hz = 1'b0;
    endtask

    task automatic set_all(input logic [31:0] t, input logic [31:0] c);
        wr(3'd0, 32'd3);
        tick();
        wr(3'd2, t);
        wr(3'd3, c);
        wr(3'd0, 32'd0);
        wr(3'd5, 32'd5);
    endtask

    task automatic test_reset();
        logic [31:0] v;
        rd(3'd2, v); check("R1 time", v, 32'h0000_0000);
        rd(3'd3, v); check("R1 cal", v, 32'h0121_0020);
        rd(3'd4, v); check("R1 status", v, 32'h0);
        rd(3'd0, v); check("R1 ctrl", v, 32'h0);
        rd(3'd1, v); check("R1 fmt", v, 32'h0);
    endtask

    task automatic test_handshake();
        logic [31:0] v;
        wr(3'd0, 32'd1);
        rd(3'd4, v); check("R8 no ack before tick", v & 32'h1, 32'h0);
        wr(3'd2, 32'h0012_3456);
        rd(3'd2, v); check("R9 write before ack ignored", v, 32'h0);
        tick();
        rd(3'd4, v); check("R8 ack after tick", v & 32'h1, 32'h1);
        wr(3'd3, 32'h1522_2320);
        rd(3'd3, v); check("R9 cal write without cal hold ignored", v, 32'h0121_0020);
        wr(3'd2, 32'h0012_3456);
        rd(3'd2, v); check("R9 write after ack", v, 32'h0012_3456);
        wr(3'd0, 32'd0);
        wr(3'd5, 32'd5);
        rd(3'd4, v); check("R11 status cleared", v, 32'h0);
    endtask

    task automatic test_24h();
        logic [31:0] v;
        wr(3'd1, 32'd0);
        set_all(32'h0023_5958, 32'h28E2_2420);
        rd(3'd2, v); check("R10 time as written", v, 32'h0023_5958);
        rd(3'd3, v); check("R10 cal as written", v, 32'h28E2_2420);
        tick();
        rd(3'd2, v); check("R2 second step", v, 32'h0023_5959);
        rd(3'd4, v); check("R11 sev on tick", v, 32'h4);
        tick();
        rd(3'd2, v); check("R2 day wrap", v, 32'h0000_0000);
        rd(3'd3, v); check("R4 R6 leap day 29, dow 7 to 1", v, 32'h2922_2420);
        set_all(32'h0010_0959, 32'h28E2_2420);
        tick();
        rd(3'd2, v); check("R2 minute carry", v, 32'h0010_1000);
    endtask

    task automatic test_calendar();
        logic [31:0] v;
        set_all(32'h0023_5959, 32'h2862_2320);
        tick(); rd(3'd3, v); check("R4 non-leap feb", v, 32'h0183_2320);
        set_all(32'h0023_5959, 32'h2862_0021);
        tick(); rd(3'd3, v); check("R4 century non-leap", v, 32'h0183_0021);
        set_all(32'h0023_5959, 32'h2862_0020);
        tick(); rd(3'd3, v); check("R4 century leap", v, 32'h2982_0020);
        set_all(32'h0023_5959, 32'h3044_2320);
        tick(); rd(3'd3, v); check("R4 30-day month", v, 32'h0165_2320);
        set_all(32'h0023_5959, 32'h31B2_9920);
        tick(); rd(3'd3, v); check("R5 year and century wrap", v, 32'h01C1_0021);
    endtask

    task automatic test_12h();
        logic [31:0] v;
        wr(3'd1, 32'd1);
        set_all(32'h0011_5959, 32'h3044_2320);
        tick(); rd(3'd2, v); check("R3 11 AM to 12 PM", v, 32'h0052_0000);
        rd(3'd3, v); check("R3 no day advance at noon", v, 32'h3044_2320);
        set_all(32'h0052_5959, 32'h3044_2320);
        tick(); rd(3'd2, v); check("R3 12 PM to 1 PM", v, 32'h0041_0000);
        set_all(32'h0051_5959, 32'h3044_2320);
        tick(); rd(3'd2, v); check("R3 midnight in 12h", v, 32'h0012_0000);
        rd(3'd3, v); check("R3 day advance at midnight", v, 32'h0165_2320);
        wr(3'd1, 32'd0);
    endtask

    task automatic test_freeze();
        logic [31:0] v;
        logic [31:0] w;
        set_all(32'h0023_5959, 32'h3044_2320);
        wr(3'd0, 32'd1);
        tick(); tick();
        rd(3'd2, v); check("R7 time held", v, 32'h0023_5959);
        rd(3'd4, v); check("R11 sev while held", v & 32'h4, 32'h4);
        wr(3'd0, 32'd2);
        tick();
        rd(3'd2, v); check("R7 time runs with cal held", v, 32'h0000_0000);
        rd(3'd3, v); check("R7 cal held, carry dropped", v, 32'h3044_2320);
        wr(3'd0, 32'd0);
        wr(3'd5, 32'd5);
        rd(3'd2, v); rd(3'd2, w);
        check("R12 two reads agree", v, w);
        tick();
        rd(3'd2, v); check("R10 resume counting", v, 32'h0000_0001);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        test_reset();
        test_handshake();
        test_24h();
        test_calendar();
        test_12h();
        test_freeze();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule